// File: doc/BRIEF.md
# Input Supply Qualifier with Power-Good Drive

This block decides whether the charger's input supply can be trusted. It takes three comparator results as single-bit flags:
- supply above the power-down threshold;
- input higher than the battery side by the detection margin;
- input over-voltage.

It first passes each flag through a two-flop synchronizer. It then filters the flags with deglitch counters that run on a fixed reference clock. The detect event uses a long window and the release event a short one. Over-voltage entry and exit each have their own short persistence window.

From the filtered state the block drives a power-good pull-down enable, which stands in for an open-drain pin: 1 pulls the pin low and 0 leaves it high impedance. It also drives a charger-enable indication. When power-good drops because the input was lost, the charger stays enabled for a long off delay. At the end of that delay a one-cycle charger-off strobe and a one-cycle timer-clear strobe are issued in the same cycle. Over-voltage is not latched: the block returns to normal on its own once the flag has been clear long enough.

All windows are parameters in reference-clock ticks. With a 1 MHz clock the defaults are:

| Parameter | Default ticks | Time |
|---|---|---|
| Detect window | 2500 | 2.5 ms |
| Release window | 10 | 10 µs |
| Over-voltage entry | 50 | 50 µs |
| Over-voltage exit | 50 | 50 µs |
| Off delay | 30000 | 30 ms |

Top module: `inpwr_qual`

## Requirements
- R1: While reset is asserted, `pg_pull_o`, `chg_en_o`, `chg_off_o` and `tmr_clr_o` are all 0.
- R2: With the supply above the power-down threshold and no over-voltage, `pg_pull_o` becomes 1 exactly DET_TICKS+2 cycles after `in_det_i` rises and stays high. The 2 cycles are the synchronizer. At the same time `chg_en_o` becomes 1.
- R3: If `in_det_i` goes low for even one cycle while the detect window is running, the window restarts from zero. Power-good then needs a further full DET_TICKS+2 cycles after the flag returns high.
- R4: `pg_pull_o` drops exactly REL_TICKS+2 cycles after `in_det_i` falls. A low pulse on the flag that is shorter than the window leaves power-good high.
- R5: `ovp_i` held high for OVS_TICKS+2 cycles drops both `pg_pull_o` and `chg_en_o` to 0. A pulse shorter than OVS_TICKS has no visible effect.
- R6: Once `ovp_i` has been low for OVC_TICKS+2 cycles, `pg_pull_o` and `chg_en_o` return to 1 without any other action, provided the input is still detected.
- R7: After power-good drops, `chg_en_o` stays 1 if the input was lost, but is 0 during over-voltage. Exactly OFF_TICKS+1 cycles after the drop, `chg_off_o` and `tmr_clr_o` are both 1 for a single cycle. From that cycle on, `chg_en_o` is 0.
- R8: If power-good returns before the off delay has expired, no off or timer-clear strobe is issued.
- R9: Exactly 2 cycles after `uv_ok_i` falls, all outputs are 0 and all filter state is cleared. No strobe is issued during power-down. After `uv_ok_i` returns, power-good again needs the full DET_TICKS+2 cycles.
- R10: The power-good pull-down encodes three cases. It is 0 (pin high impedance) when the input is not detected, 1 (pin low) when the input is detected without over-voltage, and 0 when the input is detected with over-voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 1 | Supply is above the power-down threshold |
| in_det_i | input | 1 | Input exceeds the battery side by the detection margin (hysteresis already applied) |
| ovp_i | input | 1 | Input over-voltage comparator flag |
| pg_pull_o | output | 1 | Power-good pull-down enable: 1 pulls the pin low, 0 leaves it high impedance |
| chg_en_o | output | 1 | Charger may run |
| chg_off_o | output | 1 | One-cycle charger-off strobe at the end of the off delay |
| tmr_clr_o | output | 1 | One-cycle clear for downstream timers, issued in the same cycle as `chg_off_o` |

## Verification
Two events can land on the same clock edge: the off delay can expire in the very cycle that a renewed input detection completes its window. The bench provokes this by timing the drop of `in_det_i` and its return so that the detect window ends on the exact expiry edge. It then checks the outcome. Both strobes must fire, because the power-good that was sampled before that edge was low. In the same cycle power-good must return high and the charger enable must stay high. A neighbouring case is also exercised: power-good returns a few cycles before expiry, and no strobe may appear.

// File: rtl/inpwr_qual.sv
module inpwr_qual #(
  parameter int DET_TICKS = 2500,
  parameter int REL_TICKS = 10,
  parameter int OVS_TICKS = 50,
  parameter int OVC_TICKS = 50,
  parameter int OFF_TICKS = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok_i,
  input  logic in_det_i,
  input  logic ovp_i,
  output logic pg_pull_o,
  output logic chg_en_o,
  output logic chg_off_o,
  output logic tmr_clr_o
);
  localparam int M1 = (DET_TICKS > REL_TICKS) ? DET_TICKS : REL_TICKS;
  localparam int M2 = (OVS_TICKS > OVC_TICKS) ? OVS_TICKS : OVC_TICKS;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MT = (M3 > OFF_TICKS) ? M3 : OFF_TICKS;
  localparam int CW = $clog2(MT + 1);
  localparam logic [CW-1:0] DET_END = CW'(DET_TICKS - 1);
  localparam logic [CW-1:0] REL_END = CW'(REL_TICKS - 1);
  localparam logic [CW-1:0] OVS_END = CW'(OVS_TICKS - 1);
  localparam logic [CW-1:0] OVC_END = CW'(OVC_TICKS - 1);
  localparam logic [CW-1:0] OFF_END = CW'(OFF_TICKS - 1);

  logic [2:0] sync1, sync2;
  logic s_uv, s_det, s_ov;
  logic det_q, ov_q, pg_d, pend, stb;
  logic [CW-1:0] dcnt, ocnt, fcnt;
  logic pg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {uv_ok_i, in_det_i, ovp_i};
      sync2 <= sync1;
    end

  assign {s_uv, s_det, s_ov} = sync2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      det_q <= 1'b0;
      dcnt  <= '0;
    end else if (!s_uv || s_det == det_q) begin
      if (!s_uv) det_q <= 1'b0;
      dcnt <= '0;
    end else if (dcnt == (det_q ? REL_END : DET_END)) begin
      det_q <= s_det;
      dcnt  <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ov_q <= 1'b0;
      ocnt <= '0;
    end else if (!s_uv || s_ov == ov_q) begin
      if (!s_uv) ov_q <= 1'b0;
      ocnt <= '0;
    end else if (ocnt == (ov_q ? OVC_END : OVS_END)) begin
      ov_q <= s_ov;
      ocnt <= '0;
    end else begin
      ocnt <= ocnt + 1'b1;
    end

  assign pg = s_uv & det_q & ~ov_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_d <= 1'b0;
      pend <= 1'b0;
      stb  <= 1'b0;
      fcnt <= '0;
    end else begin
      pg_d <= pg;
      stb  <= 1'b0;
      if (!s_uv) begin
        pend <= 1'b0;
        fcnt <= '0;
      end else if (pg) begin
        pend <= 1'b0;
      end else if (pg_d) begin
        pend <= 1'b1;
        fcnt <= '0;
      end else if (pend) begin
        if (fcnt == OFF_END) begin
          pend <= 1'b0;
          stb  <= 1'b1;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end
    end

  assign pg_pull_o = pg;
  assign chg_en_o  = s_uv & ~ov_q & (det_q | pend | pg_d);
  assign chg_off_o = stb;
  assign tmr_clr_o = stb;
endmodule

module inpwr_qual_chk (
  input logic clk,
  input logic rst_n,
  input logic uv_ok_i,
  input logic pg_pull_o,
  input logic chg_en_o,
  input logic chg_off_o,
  input logic tmr_clr_o
);
  assert_power_down_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(uv_ok_i, 2) |-> !pg_pull_o && !chg_en_o && !chg_off_o && !tmr_clr_o);

  assert_pg_implies_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pg_pull_o |-> chg_en_o);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_off_o |=> !chg_off_o && !tmr_clr_o);

  assert_strobe_after_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_off_o |-> !$past(pg_pull_o));

  assert_pg_needs_supply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_pull_o) |-> $past(uv_ok_i, 2));
endmodule

bind inpwr_qual inpwr_qual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_ok_i(uv_ok_i), .pg_pull_o(pg_pull_o),
  .chg_en_o(chg_en_o), .chg_off_o(chg_off_o), .tmr_clr_o(tmr_clr_o)
);

// File: tb/inpwr_qual_bench.sv
module inpwr_qual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DET = 20;
  localparam int REL = 4;
  localparam int OVS = 6;
  localparam int OVC = 5;
  localparam int OFF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, det = 1'b0, ov = 1'b0;
  logic pg, en, off, tclr;
  int compared = 0, mismatched = 0, stb_count = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inpwr_qual #(.DET_TICKS(DET), .REL_TICKS(REL), .OVS_TICKS(OVS),
               .OVC_TICKS(OVC), .OFF_TICKS(OFF)) u_inpwr_qual (
    .clk(clk), .rst_n(rst_n), .uv_ok_i(uv), .in_det_i(det), .ovp_i(ov),
    .pg_pull_o(pg), .chg_en_o(en), .chg_off_o(off), .tmr_clr_o(tclr));

  always @(negedge clk) if (off) stb_count++;

  // fields: [23:20] req, [19] uv, [18] det, [17] ov, [16] pg, [15] en, [14] stb, [13:0] wait
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {4'd9,  3'b100, 3'b000, 14'd3},        // R9 supply up, nothing detected
    {4'd2,  3'b110, 3'b000, 14'(DET+1)},   // R2 one cycle before qualification
    {4'd2,  3'b110, 3'b110, 14'd1},        // R2 qualified, R10 pin low
    {4'd4,  3'b100, 3'b110, 14'(REL+1)},   // R4 still inside release window
    {4'd4,  3'b100, 3'b010, 14'd1},        // R4 released, R7 charger held on
    {4'd7,  3'b100, 3'b010, 14'(OFF)},     // R7 one cycle before strobe
    {4'd7,  3'b100, 3'b001, 14'd1},        // R7 strobe, charger off
    {4'd7,  3'b100, 3'b000, 14'd1},        // R7 strobe lasts one cycle
    {4'd3,  3'b110, 3'b000, 14'd10},       // R3 detect window running
    {4'd3,  3'b100, 3'b000, 14'd1},        // R3 one-cycle glitch
    {4'd3,  3'b110, 3'b000, 14'(DET+1)},   // R3 window restarted
    {4'd3,  3'b110, 3'b110, 14'd1},        // R3 qualified after restart
    {4'd5,  3'b111, 3'b110, 14'(OVS+1)},   // R5 over-voltage not yet accepted
    {4'd5,  3'b111, 3'b000, 14'd1},        // R5 forced off, R10 detected+ov is high-Z
    {4'd6,  3'b110, 3'b000, 14'(OVC+1)},   // R6 still inside exit window
    {4'd6,  3'b110, 3'b110, 14'd1},        // R6 resumes unlatched
    {4'd5,  3'b111, 3'b110, 14'd3},        // R5 short over-voltage pulse
    {4'd5,  3'b110, 3'b110, 14'd10},       // R5 pulse had no effect
    {4'd9,  3'b010, 3'b110, 14'd1},        // R9 synchronizer delay
    {4'd9,  3'b010, 3'b000, 14'd1},        // R9 outputs cleared
    {4'd9,  3'b110, 3'b000, 14'(DET+1)},   // R9 full window needed again
    {4'd9,  3'b110, 3'b110, 14'd1}         // R9 requalified
  };

  task automatic chk(input int req, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d: {pg,en,off,tclr} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, {pg, en, off, tclr}, 4'b0000);   // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, {pg, en, off, tclr}, 4'b0000);   // R1 after release, inputs low

    for (int i = 0; i < NV; i++) begin
      {uv, det, ov} = VEC[i][19:17];
      repeat (int'(VEC[i][13:0])) @(negedge clk);
      chk(int'(VEC[i][23:20]), {pg, en, off, tclr},
          {VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][14]});
    end

    // R8: power-good returns before the off delay expires
    stb_count = 0;
    det = 1'b0;
    repeat (REL + 2) @(negedge clk);
    chk(8, {pg, en, off, tclr}, 4'b0100);
    repeat (5) @(negedge clk);
    det = 1'b1;
    repeat (80) @(negedge clk);
    chk(8, {pg, en, off, tclr}, 4'b1100);
    compared++;
    if (stb_count != 0) begin
      mismatched++;
      $display("FAIL R8: strobes actual %0d expected 0", stb_count);
    end

    // R7/R2: requalification completes on the expiry edge
    det = 1'b0;
    repeat (REL + 2) @(negedge clk);
    chk(7, {pg, en, off, tclr}, 4'b0100);
    repeat (OFF - 1 - DET) @(negedge clk);
    det = 1'b1;
    repeat (DET + 1) @(negedge clk);
    chk(7, {pg, en, off, tclr}, 4'b0100);
    @(negedge clk);
    chk(7, {pg, en, off, tclr}, 4'b1111);
    @(negedge clk);
    chk(2, {pg, en, off, tclr}, 4'b1100);

    // R9: no strobe while powered down
    stb_count = 0;
    uv = 1'b0;
    repeat (OFF + 20) @(negedge clk);
    compared++;
    if (stb_count != 0) begin
      mismatched++;
      $display("FAIL R9: strobes actual %0d expected 0", stb_count);
    end
    chk(9, {pg, en, off, tclr}, 4'b0000);

    // R1: reset in the middle of operation
    uv = 1'b1;
    repeat (DET + 4) @(negedge clk);
    chk(2, {pg, en, off, tclr}, 4'b1100);
    rst_n = 1'b0;
    #1;
    chk(1, {pg, en, off, tclr}, 4'b0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule